// File: doc/BRIEF.md
# Double-Clock TDM Serial Frame Port

This block is the slave side of a serial time-division-multiplexed frame bus. A data clock toggles at twice the bit rate and a frame-sync input marks the start of each frame. Every bit occupies two data-clock periods. The upstream bit is put on the line at the first rising edge of its period. The downstream bit is captured at the second falling edge of the same period. Both data lines are open-drain, so the block only pulls low and lets a one float high.

A frame holds `NSLOTS` byte slots, sent MSB first. Software-side logic fills a per-slot transmit register through a small write port. Each received byte leaves on a parallel output together with its slot number and a one-cycle strobe. A bit-rate clock, the data clock divided by two, is regenerated for neighbouring devices. The data clock, frame sync and downstream line are asynchronous inputs. They are synchronised into a faster system clock, and their edges are detected in that domain.

A frame sync that rises before a whole frame has passed restarts the counters at once and reports a frame error. A sync held high across the whole of slot 0 acts exactly like a short pulse.

Top module: `tdm_frame_port`

## Requirements
- R1: A rising edge of frame sync restarts the frame: the next launched bit is the MSB of slot 0, and the first byte reported afterwards carries slot index 0.
- R2: Each bit is launched after the first rising data-clock edge of its two-clock period, MSB first. `du_oe_o` high means the line is pulled low (bit 0), and `du_oe_o` low means the line is released (bit 1).
- R3: The downstream bit is sampled at the second falling data-clock edge of its period, and bytes are assembled MSB first.
- R4: Within a frame, `bclk_o` is high from the first rising data-clock edge of a bit to the second one and low for the rest of the bit, giving the data clock divided by two.
- R5: The transmit byte of each slot comes from a per-slot register written when `wr_en_i` is high at `wr_slot_i`. The reset value is 0xFF, so an unwritten slot keeps the line released for all 8 bits.
- R6: Once `NSLOTS`*8 bits have been exchanged, the block stays idle with the line released and reports no bytes until the next frame-sync rise.
- R7: After the eighth bit of a slot is sampled, `rx_valid_o` pulses for exactly one cycle, with `rx_data_o` holding the byte and `rx_slot_o` holding its slot index.
- R8: A frame sync held high for the whole of slot 0 gives the same transmit and receive results as a one-bit sync pulse. Only its rising edge matters.
- R9: A frame-sync rise before `NSLOTS`*8 bits are complete gives a one-cycle `frame_err_o` pulse and a restart. A rise after a complete frame, or the first rise after reset, gives no error.
- R10: In reset, `du_oe_o`, `bclk_o`, `rx_valid_o` and `frame_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_i | input | 1 | Data clock at twice the bit rate (asynchronous) |
| fsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| dd_i | input | 1 | Downstream serial data line |
| du_oe_o | output | 1 | Open-drain enable for the upstream line (1 = pull low) |
| bclk_o | output | 1 | Regenerated bit-rate clock |
| wr_en_i | input | 1 | Transmit register write strobe |
| wr_slot_i | input | $clog2(NSLOTS) | Slot index of the write |
| wr_data_i | input | 8 | Transmit byte to store |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_slot_o | output | $clog2(NSLOTS) | Slot index of the received byte |
| rx_data_o | output | 8 | Received byte |
| frame_err_o | output | 1 | One-cycle pulse on an early frame sync |

## Verification
The bound assertions check several rules on every cycle:

- The upstream line is pulled low only just after a detected data-clock rise.
- The bit clock changes only after a rise.
- Received bytes appear only after a falling edge, as single-cycle strobes with slot indices in range.
- Errors appear only right after a sync rise.
- The line is released straight after a resync.

Other behaviour needs whole frames, so only the bench scenarios can show it: the bit order on the wire, the received byte values, the default all-ones slots, the idle state after the last slot, the tolerance of a long sync, and the restart from slot 0 after a short frame.

// File: rtl/tdm_frame_port.sv
module tdm_frame_port #(
  parameter int NSLOTS = 12,
  parameter int SYNC   = 2,
  localparam int SW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk_i,
  input  logic          fsync_i,
  input  logic          dd_i,
  output logic          du_oe_o,
  output logic          bclk_o,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_slot_i,
  input  logic [7:0]    wr_data_i,
  output logic          rx_valid_o,
  output logic [SW-1:0] rx_slot_o,
  output logic [7:0]    rx_data_o,
  output logic          frame_err_o
);
  localparam logic [SW-1:0] LAST = SW'(NSLOTS - 1);

  logic [SYNC-1:0] dclk_sync, fs_sync, dd_sync;
  logic            dclk_q, fs_q;
  logic            d_rise, d_fall, f_rise, dd_s;

  logic            active, half, tx_bit, bclk_q;
  logic [2:0]      bit_idx;
  logic [SW-1:0]   slot;
  logic [6:0]      rx_sh;
  logic [7:0]      tx_mem [NSLOTS];
  logic [7:0]      cur_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclk_sync <= '0;
      fs_sync   <= '0;
      dd_sync   <= '1;
      dclk_q    <= 1'b0;
      fs_q      <= 1'b0;
    end else begin
      dclk_sync <= {dclk_sync[SYNC-2:0], dclk_i};
      fs_sync   <= {fs_sync[SYNC-2:0], fsync_i};
      dd_sync   <= {dd_sync[SYNC-2:0], dd_i};
      dclk_q    <= dclk_sync[SYNC-1];
      fs_q      <= fs_sync[SYNC-1];
    end
  end

  assign d_rise   = dclk_sync[SYNC-1] & ~dclk_q;
  assign d_fall   = ~dclk_sync[SYNC-1] & dclk_q;
  assign f_rise   = fs_sync[SYNC-1] & ~fs_q;
  assign dd_s     = dd_sync[SYNC-1];
  assign cur_byte = tx_mem[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) tx_mem[i] <= 8'hFF;
    end else if (wr_en_i && wr_slot_i <= LAST) begin
      tx_mem[wr_slot_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      half        <= 1'b0;
      tx_bit      <= 1'b1;
      bclk_q      <= 1'b0;
      bit_idx     <= '0;
      slot        <= '0;
      rx_sh       <= '0;
      rx_valid_o  <= 1'b0;
      rx_slot_o   <= '0;
      rx_data_o   <= '0;
      frame_err_o <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (f_rise) begin
        frame_err_o <= active;
        active      <= 1'b1;
        half        <= 1'b0;
        bit_idx     <= '0;
        slot        <= '0;
        tx_bit      <= 1'b1;
        bclk_q      <= 1'b0;
      end else if (active) begin
        if (d_rise) begin
          if (!half) begin
            tx_bit <= cur_byte[3'd7 - bit_idx];
            bclk_q <= 1'b1;
          end else begin
            bclk_q <= 1'b0;
          end
        end
        if (d_fall) begin
          half <= ~half;
          if (half) begin
            rx_sh   <= {rx_sh[5:0], dd_s};
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= {rx_sh, dd_s};
              rx_slot_o  <= slot;
              if (slot == LAST) begin
                active <= 1'b0;
                tx_bit <= 1'b1;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign du_oe_o = active & ~tx_bit;
  assign bclk_o  = bclk_q;
endmodule

// File: rtl/tdm_frame_port_chk.sv
module tdm_frame_port_chk #(
  parameter int NSLOTS = 12,
  localparam int SW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          d_rise,
  input logic          d_fall,
  input logic          f_rise,
  input logic          du_oe_o,
  input logic          bclk_o,
  input logic          rx_valid_o,
  input logic [SW-1:0] rx_slot_o,
  input logic          frame_err_o
);
  p_launch_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(du_oe_o) |-> $past(d_rise));

  p_bclk_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_o) |-> $past(d_rise) || $past(f_rise));

  p_rx_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(d_fall));

  p_rx_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_rx_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_slot_o <= SW'(NSLOTS - 1));

  p_err_after_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> $past(f_rise));

  p_release_on_resync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    f_rise |=> !du_oe_o);
endmodule

bind tdm_frame_port tdm_frame_port_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .d_rise      (d_rise),
  .d_fall      (d_fall),
  .f_rise      (f_rise),
  .du_oe_o     (du_oe_o),
  .bclk_o      (bclk_o),
  .rx_valid_o  (rx_valid_o),
  .rx_slot_o   (rx_slot_o),
  .frame_err_o (frame_err_o)
);

// File: tb/tdm_frame_port_tb.sv
module tdm_frame_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int NS         = 12;
  localparam int SW         = $clog2(NS);
  // {tx byte, rx byte} per slot
  localparam logic [15:0] VEC [NS] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80,
    16'h80_01, 16'h3C_A5, 16'hF0_0F, 16'h0F_F0, 16'h96_69, 16'h7E_81};

  logic clk = 1'b0, rst_n = 1'b0;
  logic dclk = 1'b0, fsync = 1'b0, dd = 1'b1;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [7:0] wr_data = '0;
  logic du_oe_o, bclk_o, rx_valid_o, frame_err_o;
  logic [SW-1:0] rx_slot_o;
  logic [7:0] rx_data_o;

  int n_chk = 0, n_fail = 0;
  int rx_n = 0, err_n = 0, first_slot = -1, bclk_bad = 0, oe_n = 0;
  logic [7:0] rx_pat [NS];
  logic [7:0] rx_got [NS];
  logic [7:0] tx_seen [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_frame_port #(.NSLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .fsync_i(fsync), .dd_i(dd),
    .du_oe_o(du_oe_o), .bclk_o(bclk_o), .wr_en_i(wr_en), .wr_slot_i(wr_slot),
    .wr_data_i(wr_data), .rx_valid_o(rx_valid_o), .rx_slot_o(rx_slot_o),
    .rx_data_o(rx_data_o), .frame_err_o(frame_err_o));

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o) begin
        if (rx_n == 0) first_slot = int'(rx_slot_o);
        rx_got[rx_slot_o] = rx_data_o;
        rx_n++;
      end
      if (frame_err_o) err_n++;
      if (du_oe_o) oe_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(s); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw();
    repeat (HP) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits, input bit long_fs);
    rx_n = 0; first_slot = -1; bclk_bad = 0;
    fsync = 1'b1;
    hw();
    for (int b = 0; b < nbits; b++) begin
      int s = b / 8;
      int k = 7 - (b % 8);
      dd = rx_pat[s][k];
      dclk = 1'b1;
      repeat (HP - 1) @(negedge clk);
      tx_seen[s][k] = ~du_oe_o;
      if (!bclk_o) bclk_bad++;
      @(negedge clk);
      dclk = 1'b0;
      if (!long_fs && b == 0) fsync = 1'b0;
      hw();
      dclk = 1'b1;
      repeat (HP - 1) @(negedge clk);
      if (bclk_o) bclk_bad++;
      @(negedge clk);
      dclk = 1'b0;
      if (long_fs && b == 7) fsync = 1'b0;
      hw();
    end
    fsync = 1'b0;
    hw();
  endtask

  task automatic check_frame(input string tag, input bit tx_default);
    for (int s = 0; s < NS; s++) begin
      logic [7:0] et = tx_default ? 8'hFF : VEC[s][15:8];
      chk(tx_seen[s] == et, {tag, " R2/R5 tx"}, int'(tx_seen[s]), int'(et));
      chk(rx_got[s] == rx_pat[s], {tag, " R3 rx"}, int'(rx_got[s]), int'(rx_pat[s]));
    end
    chk(rx_n == NS, {tag, " R7 byte count"}, rx_n, NS);
    chk(first_slot == 0, {tag, " R1 first slot"}, first_slot, 0);
    chk(bclk_bad == 0, {tag, " R4 bclk phase"}, bclk_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(du_oe_o == 1'b0, "R10 du_oe", int'(du_oe_o), 0);
    chk(bclk_o == 1'b0, "R10 bclk", int'(bclk_o), 0);
    chk(rx_valid_o == 1'b0, "R10 rx_valid", int'(rx_valid_o), 0);
    chk(frame_err_o == 1'b0, "R10 frame_err", int'(frame_err_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int s = 0; s < NS; s++) rx_pat[s] = VEC[s][7:0];
    run_frame(NS * 8, 1'b0);
    check_frame("unwritten", 1'b1);
    chk(err_n == 0, "R9 first sync no error", err_n, 0);

    for (int s = 0; s < NS; s++) wr(s, VEC[s][15:8]);
    run_frame(NS * 8, 1'b0);
    check_frame("table", 1'b0);

    oe_n = 0; rx_n = 0;
    for (int c = 0; c < 6; c++) begin
      dd = 1'b0; dclk = 1'b1; hw(); dclk = 1'b0; hw();
    end
    chk(oe_n == 0, "R6 idle line released", oe_n, 0);
    chk(rx_n == 0, "R6 idle no bytes", rx_n, 0);

    for (int s = 0; s < NS; s++) rx_pat[s] = ~VEC[s][7:0];
    run_frame(NS * 8, 1'b1);
    check_frame("long sync R8", 1'b0);
    chk(err_n == 0, "R9 complete frames no error", err_n, 0);

    run_frame(20, 1'b0);
    chk(rx_n == 2, "R7 partial frame bytes", rx_n, 2);
    for (int s = 0; s < NS; s++) rx_pat[s] = VEC[NS - 1 - s][7:0];
    run_frame(NS * 8, 1'b0);
    chk(err_n == 1, "R9 early sync error", err_n, 1);
    check_frame("resync R1", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule